// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the coherence state and the speculation bits for every line of a small tag store that sits at the level where thread-level speculation is enforced. One operation per cycle names a line and is one of: a speculative load, a speculative store, an invalidation arriving from another epoch, or a replacement request. Each line records whether a speculative load has read it and whether a speculative store has written it. These two bits decide three things: whether an incoming invalidation violates the running epoch, whether the line may be evicted, and what happens to the line when the epoch commits or is squashed.

A speculative store to a line held only in shared form is noted in a small ownership buffer, so that exclusive ownership can be taken at commit time. When the buffer is full, such a store is stalled. A commit pulse turns speculative states back into their plain forms and marks written lines dirty. A squash pulse throws away every written line. Both pulses clear all speculation bits and empty the buffer.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is invalid with clear bits, the buffer count is zero and all three flags are low. `line_status[6*i +: 6]` gives line i as {written, read, dirty, state[2:0]}, with state codes invalid=0, shared=1, exclusive=2, speculative-shared=3, speculative-exclusive=4.
- R2: A load (op_kind=0) sets the line's read bit. Invalid and shared lines become speculative-shared, exclusive lines become speculative-exclusive, and speculative states stay as they are.
- R3: A store (op_kind=1) to an exclusive or speculative-exclusive line makes it speculative-exclusive with the written bit set. A store to an invalid, shared or speculative-shared line whose written bit is clear makes it speculative-shared with the written bit set, and appends its index to the ownership buffer. A repeated store to a line that already has the written bit set adds no second entry.
- R4: An invalidation (op_kind=2) raises `violation` for one cycle, one cycle later, only when the line is not invalid, its read bit is set and `op_earlier` is 1.
- R5: An invalidation of a line with both bits clear makes it invalid and clears its dirty bit. An invalidation of a line with either bit set leaves the line unchanged.
- R6: A replacement (op_kind=3) of a line with either bit set raises `repl_blocked` for one cycle, one cycle later, and leaves the line unchanged. Otherwise the line becomes invalid with its dirty bit clear.
- R7: A store that needs a buffer entry while the buffer holds ORB_DEPTH entries raises `store_stall` for one cycle, one cycle later, and leaves the line and the buffer unchanged.
- R8: On commit, written lines become exclusive and dirty, speculative-exclusive lines become exclusive, and speculative-shared lines become shared.
- R9: On squash, written lines become invalid with dirty clear, speculative-exclusive lines become exclusive, and speculative-shared lines become shared.
- R10: Commit and squash both clear every read and written bit and empty the buffer. Squash wins when both are asserted, and any operation presented in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 0 load, 1 store, 2 invalidation, 3 replacement |
| op_line | input | IDX_W | Index of the target line |
| op_earlier | input | 1 | Invalidation comes from a logically earlier epoch |
| commit_req | input | 1 | Epoch commit pulse |
| squash_req | input | 1 | Epoch squash pulse |
| violation | output | 1 | Dependence violation detected |
| repl_blocked | output | 1 | Replacement refused because the line is locked |
| store_stall | output | 1 | Store held back because the buffer is full |
| orb_count | output | CNT_W | Entries in the ownership buffer |
| orb_lines | output | ORB_DEPTH*IDX_W | Buffered line indices, entry 0 in the low bits |
| line_status | output | NUM_LINES*6 | Per-line state and bits |

## Verification
The bench builds the tracker with eight lines and an ownership buffer only two entries deep. With so shallow a buffer, random stores reach the full-buffer stall often, not only in directed cases. Eight lines keep the random traffic dense enough that loads, stores and invalidations pile up on the same lines between commits and squashes. This exercises violations, locked replacements and written lines meeting both the commit path and the squash path.

// File: rtl/spec_pkg.sv
package spec_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHR = 3'd1,
    LS_EXC = 3'd2,
    LS_SPS = 3'd3,
    LS_SPE = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_INVAL = 2'd2,
    OP_REPL  = 2'd3
  } op_e;

  localparam int STATUS_W = 6;

endpackage

// File: rtl/spec_line_cell.sv
module spec_line_cell
  import spec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sel,
  input  op_e      kind,
  input  logic     inv_earlier,
  input  logic     commit_go,
  input  logic     squash_go,
  input  logic     orb_full,
  output line_st_e st,
  output logic     sl,
  output logic     sm,
  output logic     dirty,
  output logic     viol_hit,
  output logic     block_hit,
  output logic     push_req,
  output logic     stall_hit
);

  line_st_e st_n;
  logic     sl_n, sm_n, dirty_n;
  logic     present, shared_like, locked, need_own;

  assign present     = (st != LS_INV);
  assign shared_like = (st == LS_INV) || (st == LS_SHR) || (st == LS_SPS);
  assign locked      = sl | sm;
  assign need_own    = sel && (kind == OP_STORE) && shared_like && !sm;

  assign viol_hit  = sel && (kind == OP_INVAL) && present && sl && inv_earlier;
  assign block_hit = sel && (kind == OP_REPL) && locked;
  assign push_req  = need_own && !orb_full;
  assign stall_hit = need_own && orb_full;

  always_comb begin
    st_n    = st;
    sl_n    = sl;
    sm_n    = sm;
    dirty_n = dirty;
    if (squash_go) begin
      if (sm) begin
        st_n    = LS_INV;
        dirty_n = 1'b0;
      end else if (st == LS_SPE) begin
        st_n = LS_EXC;
      end else if (st == LS_SPS) begin
        st_n = LS_SHR;
      end
      sl_n = 1'b0;
      sm_n = 1'b0;
    end else if (commit_go) begin
      if (sm) begin
        st_n    = LS_EXC;
        dirty_n = 1'b1;
      end else if (st == LS_SPE) begin
        st_n = LS_EXC;
      end else if (st == LS_SPS) begin
        st_n = LS_SHR;
      end
      sl_n = 1'b0;
      sm_n = 1'b0;
    end else if (sel) begin
      case (kind)
        OP_LOAD: begin
          sl_n = 1'b1;
          if (st == LS_INV || st == LS_SHR) st_n = LS_SPS;
          else if (st == LS_EXC)            st_n = LS_SPE;
        end
        OP_STORE: begin
          if (st == LS_EXC || st == LS_SPE) begin
            st_n = LS_SPE;
            sm_n = 1'b1;
          end else if (!stall_hit) begin
            st_n = LS_SPS;
            sm_n = 1'b1;
          end
        end
        OP_INVAL, OP_REPL: begin
          if (!locked) begin
            st_n    = LS_INV;
            dirty_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LS_INV;
      sl    <= 1'b0;
      sm    <= 1'b0;
      dirty <= 1'b0;
    end else begin
      st    <= st_n;
      sl    <= sl_n;
      sm    <= sm_n;
      dirty <= dirty_n;
    end
  end

  // A locked line keeps its state through a refused replacement
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (block_hit && !commit_go && !squash_go) |=> (st == $past(st)));

  // A stalled store leaves the written bit as it was
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stall_hit && !commit_go && !squash_go) |=> (sm == $past(sm)));

  // A squashed written line ends invalid
  assert_squash_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (squash_go && sm) |=> (st == LS_INV && !dirty));

  // A committed written line ends exclusive and dirty
  assert_commit_dirty_R8: assert property (@(posedge clk) disable iff (rst)
    (commit_go && sm) |=> (st == LS_EXC && dirty));

endmodule

// File: rtl/spec_orb.sv
module spec_orb #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [IDX_W-1:0]       push_idx,
  input  logic                   clear,
  output logic                   full,
  output logic [CNT_W-1:0]       count,
  output logic [DEPTH*IDX_W-1:0] entries
);

  logic [IDX_W-1:0] mem [DEPTH];

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !clear && !full) mem[count[PTR_W-1:0]] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)          count <= '0;
    else if (push && !full)    count <= count + 1'b1;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign entries[k*IDX_W +: IDX_W] = mem[k];
  end

  assert_orb_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_orb_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import spec_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ORB_DEPTH = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int CNT_W = $clog2(ORB_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_valid,
  input  logic [1:0]                 op_kind,
  input  logic [IDX_W-1:0]           op_line,
  input  logic                       op_earlier,
  input  logic                       commit_req,
  input  logic                       squash_req,
  output logic                       violation,
  output logic                       repl_blocked,
  output logic                       store_stall,
  output logic [CNT_W-1:0]           orb_count,
  output logic [ORB_DEPTH*IDX_W-1:0] orb_lines,
  output logic [NUM_LINES*STATUS_W-1:0] line_status
);

  logic squash_go, commit_go, op_go, orb_full, orb_clear;
  logic [NUM_LINES-1:0] viol_vec, block_vec, push_vec, stall_vec, sl_vec, sm_vec;
  op_e kind;

  assign squash_go = squash_req;
  assign commit_go = commit_req && !squash_req;
  assign op_go     = op_valid && !commit_req && !squash_req;
  assign orb_clear = commit_req || squash_req;
  assign kind      = op_e'(op_kind);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_st_e st;
    logic     dirty;
    logic     sel;

    assign sel = op_go && (op_line == IDX_W'(i));

    spec_line_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .sel        (sel),
      .kind       (kind),
      .inv_earlier(op_earlier),
      .commit_go  (commit_go),
      .squash_go  (squash_go),
      .orb_full   (orb_full),
      .st         (st),
      .sl         (sl_vec[i]),
      .sm         (sm_vec[i]),
      .dirty      (dirty),
      .viol_hit   (viol_vec[i]),
      .block_hit  (block_vec[i]),
      .push_req   (push_vec[i]),
      .stall_hit  (stall_vec[i])
    );

    assign line_status[i*STATUS_W +: STATUS_W] = {sm_vec[i], sl_vec[i], dirty, st};
  end

  spec_orb #(.DEPTH(ORB_DEPTH), .IDX_W(IDX_W)) u_orb (
    .clk     (clk),
    .rst     (rst),
    .push    (|push_vec),
    .push_idx(op_line),
    .clear   (orb_clear),
    .full    (orb_full),
    .count   (orb_count),
    .entries (orb_lines)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      violation    <= 1'b0;
      repl_blocked <= 1'b0;
      store_stall  <= 1'b0;
    end else begin
      violation    <= |viol_vec;
      repl_blocked <= |block_vec;
      store_stall  <= |stall_vec;
    end
  end

  assert_viol_cause_R4: assert property (@(posedge clk) disable iff (rst)
    violation |-> $past(op_valid && op_kind == 2'd2 && op_earlier && !commit_req && !squash_req));

  assert_block_cause_R6: assert property (@(posedge clk) disable iff (rst)
    repl_blocked |-> $past(op_valid && op_kind == 2'd3));

  assert_stall_full_R7: assert property (@(posedge clk) disable iff (rst)
    store_stall |-> $past(orb_full));

  assert_spec_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (commit_req || squash_req) |=> ((sl_vec | sm_vec) == '0 && orb_count == '0));

endmodule

// File: tb/spec_line_tracker_test.sv
module spec_line_tracker_test;

  localparam int NL = 8;
  localparam int OD = 2;
  localparam int IW = 3;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [IW-1:0] op_line = '0;
  logic op_earlier = 1'b0;
  logic commit_req = 1'b0;
  logic squash_req = 1'b0;
  logic violation, repl_blocked, store_stall;
  logic [CW-1:0] orb_count;
  logic [OD*IW-1:0] orb_lines;
  logic [NL*6-1:0] line_status;

  spec_line_tracker #(.NUM_LINES(NL), .ORB_DEPTH(OD)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_line(op_line), .op_earlier(op_earlier), .commit_req(commit_req),
    .squash_req(squash_req), .violation(violation), .repl_blocked(repl_blocked),
    .store_stall(store_stall), .orb_count(orb_count), .orb_lines(orb_lines),
    .line_status(line_status)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int m_st [NL];
  bit m_sl [NL], m_sm [NL], m_dt [NL];
  int m_orb [OD];
  int m_cnt;
  bit e_viol, e_blk, e_stall;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NL*6-1:0] exp_status();
    logic [NL*6-1:0] v;
    for (int i = 0; i < NL; i++)
      v[i*6 +: 6] = {m_sm[i], m_sl[i], m_dt[i], 3'(m_st[i])};
    return v;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NL; i++) begin
      m_st[i] = 0; m_sl[i] = 0; m_sm[i] = 0; m_dt[i] = 0;
    end
    m_cnt = 0; e_viol = 0; e_blk = 0; e_stall = 0;
  endfunction

  function automatic void model(bit v, int k, int l, bit er, bit cm, bit sq);
    e_viol = 0; e_blk = 0; e_stall = 0;
    if (sq || cm) begin
      for (int i = 0; i < NL; i++) begin
        if (m_sm[i]) begin
          m_st[i] = sq ? 0 : 2;
          m_dt[i] = !sq;
        end else if (m_st[i] == 4) m_st[i] = 2;
        else if (m_st[i] == 3) m_st[i] = 1;
        m_sl[i] = 0; m_sm[i] = 0;
      end
      m_cnt = 0;
    end else if (v) begin
      case (k)
        0: begin
          m_sl[l] = 1;
          if (m_st[l] == 0 || m_st[l] == 1) m_st[l] = 3;
          else if (m_st[l] == 2) m_st[l] = 4;
        end
        1: begin
          if (m_st[l] == 2 || m_st[l] == 4) begin
            m_st[l] = 4; m_sm[l] = 1;
          end else if (!m_sm[l]) begin
            if (m_cnt == OD) e_stall = 1;
            else begin
              m_st[l] = 3; m_sm[l] = 1; m_orb[m_cnt] = l; m_cnt++;
            end
          end
        end
        2: begin
          if (m_st[l] != 0 && m_sl[l] && er) e_viol = 1;
          if (!(m_sl[l] || m_sm[l])) begin m_st[l] = 0; m_dt[l] = 0; end
        end
        default: begin
          if (m_sl[l] || m_sm[l]) e_blk = 1;
          else begin m_st[l] = 0; m_dt[l] = 0; end
        end
      endcase
    end
  endfunction

  task automatic compare(string tag);
    check(tag, "violation", violation, e_viol);
    check(tag, "repl_blocked", repl_blocked, e_blk);
    check(tag, "store_stall", store_stall, e_stall);
    check(tag, "orb_count", orb_count, m_cnt);
    for (int i = 0; i < m_cnt; i++)
      check(tag, "orb_entry", orb_lines[i*IW +: IW], m_orb[i]);
    check(tag, "line_status", line_status, exp_status());
  endtask

  // Called at a negedge: drive, let one posedge pass, compare at the next negedge
  task automatic step(string tag, bit v, int k, int l, bit er, bit cm, bit sq);
    op_valid = v; op_kind = 2'(k); op_line = IW'(l); op_earlier = er;
    commit_req = cm; squash_req = sq;
    model(v, k, l, er, cm, sq);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1");

    // directed
    step("R2", 1, 0, 0, 0, 0, 0);          // load line0: I -> SpS
    step("R3", 1, 1, 1, 0, 0, 0);          // store line1: I -> SpS, buffered
    step("R3", 1, 1, 1, 0, 0, 0);          // repeated store: no new entry
    step("R8", 0, 0, 0, 0, 1, 0);          // commit: line1 E dirty, line0 S
    step("R2", 1, 0, 1, 0, 0, 0);          // load line1: E -> SpE
    step("R3", 1, 1, 1, 0, 0, 0);          // store line1: SpE, written
    step("R5", 1, 2, 0, 1, 0, 0);          // inval clean shared line0 -> I, no violation
    step("R2", 1, 0, 3, 0, 0, 0);          // load line3
    step("R4", 1, 2, 3, 0, 0, 0);          // later-epoch inval: no violation
    step("R4", 1, 2, 3, 1, 0, 0);          // earlier-epoch inval: violation
    step("R4", 1, 2, 2, 1, 0, 0);          // inval of absent line: no violation
    step("R6", 1, 3, 3, 0, 0, 0);          // replace locked line: blocked
    step("R6", 1, 3, 2, 0, 0, 0);          // replace unlocked line
    step("R3", 1, 1, 4, 0, 0, 0);
    step("R3", 1, 1, 5, 0, 0, 0);          // buffer full
    step("R7", 1, 1, 6, 0, 0, 0);          // stall, line6 untouched
    step("R7", 1, 1, 4, 0, 0, 0);          // written line, no stall
    step("R10", 1, 1, 7, 0, 1, 1);         // squash wins, op ignored
    step("R9", 1, 0, 1, 0, 0, 0);
    step("R9", 1, 1, 1, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1);          // squash: written line1 dropped

    // random
    for (int n = 0; n < 4000; n++) begin
      int k, l;
      bit v, er, cm, sq;
      string tag;
      k  = int'($urandom % 4);
      l  = int'($urandom % NL);
      v  = ($urandom % 8) != 0;
      er = $urandom % 2;
      cm = ($urandom % 40) == 0;
      sq = ($urandom % 50) == 0;
      if (sq)      tag = (cm || v) ? "R10" : "R9";
      else if (cm) tag = v ? "R10" : "R8";
      else if (!v) tag = "R1";
      else case (k)
        0: tag = "R2";
        1: tag = (m_cnt == OD) ? "R7" : "R3";
        2: tag = er ? "R4" : "R5";
        default: tag = "R6";
      endcase
      step(tag, v, k, l, er, cm, sq);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule